// File: doc/BRIEF.md
# External Data Memory Access Router

This block sits between a CPU's external-data load/store path and two possible targets. One target is an on-chip expanded RAM. The other is a slow multiplexed external bus. Each request carries:
- a direction;
- an address mode: an 8-bit register-indirect form, or a 16-bit pointer form;
- an address;
- write data.

The router decides where the request goes from the address, the mode and three configuration inputs: an external-only select, a two-bit visible-size select and a strobe-stretch select.

A request routed inside drives one cycle on the synchronous RAM port. All external pins stay quiet. A request routed outside runs a bus cycle in three phases:
1. An address-latch phase. The low address byte is on the shared address/data lines. The high byte is on a separate port when the pointer form is used.
2. An active-low read or write strobe of 6 or 30 clocks.
3. A release phase.

Either path ends with a one-cycle done pulse, with read data valid in that cycle. The size select lets software hide the upper part of the on-chip RAM, so that devices on the external bus can use those addresses.

Top module: `xdata_router`

## Requirements
- R1: While reset is asserted and right after it, `ale` is 0, `wr_n` and `rd_n` are 1, `ad_oe`, `hi_oe`, `ram_en`, `done` and `busy` are 0.
- R2: With `cfg_ext_only`=0, a narrow request (`req_wide`=0) always goes to the on-chip RAM at address {00, `req_addr[7:0]`}; `req_addr[15:8]` is ignored.
- R3: With `cfg_ext_only`=0, a wide request goes to the on-chip RAM at `req_addr[9:0]` when `req_addr` is below the visible limit (`cfg_size`+1)*256: 00=256, 01=512, 10=768, 11=1024 bytes.
- R4: During an internal access, `ale`=0, `wr_n`=`rd_n`=1, `ad_oe`=`hi_oe`=0, and `ad_out` and `hi_addr` keep their previous values.
- R5: With `cfg_ext_only`=0, a wide request at or above the visible limit runs an external cycle and does not enable the RAM.
- R6: With `cfg_ext_only`=1, every request runs an external cycle, whatever its address and mode.
- R7: An external cycle starts with exactly one clock of `ale`=1. In that clock `ad_oe`=1 and `ad_out`=`req_addr[7:0]`. For a wide request, `hi_oe`=1 and `hi_addr`=`req_addr[15:8]` through the latch and strobe phases.
- R8: For a narrow external request, `hi_oe` stays 0 and `hi_addr` keeps its previous value.
- R9: The strobe (`wr_n` or `rd_n` low) lasts 6 clocks with `cfg_stretch`=0 and 30 clocks with `cfg_stretch`=1. The two strobes are never low together.
- R10: During a write strobe, `ad_oe`=1 and `ad_out` equals the write data. During a read strobe, `ad_oe`=0, and `ad_in` as seen in the last strobe clock is returned on `rdata`.
- R11: `done` is high for exactly one clock, with `rdata` valid for reads. Counting from the clock edge that accepts the request, `done` is high in the 2nd clock for an internal access and in clock N+2 for an external one, where N is the strobe length.
- R12: A request presented while `busy`=1 is ignored: it causes no RAM access, no second address phase and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit pointer form, 0 = 8-bit register-indirect form |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| cfg_ext_only | input | 1 | Send every request to the external bus |
| cfg_size | input | 2 | Visible on-chip size, (value+1)*256 bytes |
| cfg_stretch | input | 1 | Select the long strobe |
| ram_en | output | 1 | On-chip RAM enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 10 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data, one clock after enable |
| ad_out | output | 8 | Multiplexed address/data output |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | 8 | Multiplexed address/data input |
| hi_addr | output | 8 | High address byte |
| hi_oe | output | 1 | Output enable for hi_addr |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe |
| rdata | output | 8 | Read data, valid with done |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench builds the router with its default parameters:
- a 256-byte page;
- a 10-bit RAM address;
- strobes of 6 and 30 clocks.

With these values, all four size settings and both strobe lengths can be reached within a short run. Both sides of the 256, 512, 768 and 1024 byte limits can be exercised by addresses such as 0x00FF/0x0100, 0x02F0 and 0x03FF/0x0400. The long strobe keeps a bus cycle open for 30 clocks, which leaves room to present a competing request while the router is busy.

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int PAGE_BYTES   = 256,
  parameter int RAM_AW       = 10,
  parameter int STROBE_SHORT = 6,
  parameter int STROBE_LONG  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              cfg_ext_only,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_stretch,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  input  logic [7:0]        ad_in,
  output logic [7:0]        hi_addr,
  output logic              hi_oe,
  output logic              ale,
  output logic              wr_n,
  output logic              rd_n,
  output logic [7:0]        rdata,
  output logic              done,
  output logic              busy
);
  localparam int CNT_W = $clog2(STROBE_LONG + 1);

  typedef enum logic [2:0] {S_IDLE, S_INT, S_ALE, S_STRB, S_FIN} state_t;

  state_t            st;
  logic              wr_q, wide_q, int_q, str_q;
  logic [RAM_AW-1:0] ram_q;
  logic [7:0]        wdata_q, rd_q, ad_q, hi_q;
  logic [CNT_W-1:0]  cnt;

  logic [16:0] vis_limit;
  logic        go_int, accept, strb;

  assign vis_limit = ({15'd0, cfg_size} + 17'd1) * 17'(PAGE_BYTES);
  assign go_int    = !cfg_ext_only && (!req_wide || ({1'b0, req_addr} < vis_limit));
  assign accept    = req_valid && (st == S_IDLE);
  assign strb      = (st == S_STRB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      int_q   <= 1'b0;
      str_q   <= 1'b0;
      ram_q   <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      ad_q    <= '0;
      hi_q    <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          wr_q    <= req_write;
          wide_q  <= req_wide;
          int_q   <= go_int;
          str_q   <= cfg_stretch;
          wdata_q <= req_wdata;
          ram_q   <= req_wide ? req_addr[RAM_AW-1:0] : RAM_AW'(req_addr[7:0]);
          if (go_int) begin
            st <= S_INT;
          end else begin
            st   <= S_ALE;
            ad_q <= req_addr[7:0];
            if (req_wide) hi_q <= req_addr[15:8];
          end
        end
        S_INT: st <= S_FIN;
        S_ALE: begin
          if (wr_q) ad_q <= wdata_q;
          cnt <= str_q ? CNT_W'(STROBE_LONG - 1) : CNT_W'(STROBE_SHORT - 1);
          st  <= S_STRB;
        end
        S_STRB: begin
          if (cnt == '0) begin
            if (!wr_q) rd_q <= ad_in;
            st <= S_FIN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ram_en    = (st == S_INT);
  assign ram_we    = ram_en && wr_q;
  assign ram_addr  = ram_q;
  assign ram_wdata = wdata_q;

  assign ale     = (st == S_ALE);
  assign ad_out  = ad_q;
  assign ad_oe   = ale || (strb && wr_q);
  assign hi_addr = hi_q;
  assign hi_oe   = wide_q && (ale || strb);
  assign wr_n    = !(strb && wr_q);
  assign rd_n    = !(strb && !wr_q);

  assign done  = (st == S_FIN);
  assign rdata = int_q ? ram_rdata : rd_q;
  assign busy  = (st != S_IDLE);
endmodule

// File: rtl/xdata_router_chk.sv
module xdata_router_chk #(
  parameter int SHORT = 6,
  parameter int LONG  = 30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ram_en,
  input logic       ale,
  input logic       wr_n,
  input logic       rd_n,
  input logic       ad_oe,
  input logic       hi_oe,
  input logic [7:0] ad_out,
  input logic [7:0] hi_addr,
  input logic       done
);
  localparam int LW = $clog2(LONG + 2);

  logic [LW-1:0] len;
  logic          low_q;
  logic          quiet;

  assign quiet = wr_n && rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len   <= '0;
      low_q <= 1'b0;
    end else begin
      low_q <= !quiet;
      if (!quiet) len <= low_q ? len + 1'b1 : LW'(1);
    end
  end

  a_r4_int_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (!ale && wr_n && rd_n && !ad_oe && !hi_oe));

  a_r4_int_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> ($stable(ad_out) && $stable(hi_addr)));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));

  a_r9_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiet) |-> (len == LW'(SHORT) || len == LW'(LONG)));

  a_r7_ale_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && quiet));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> !(ale || !quiet));
endmodule

bind xdata_router xdata_router_chk #(.SHORT(STROBE_SHORT), .LONG(STROBE_LONG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ram_en(ram_en), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
  .ad_oe(ad_oe), .hi_oe(hi_oe), .ad_out(ad_out), .hi_addr(hi_addr), .done(done)
);

// File: tb/tb_xdata_router.sv
module tb_xdata_router;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        xo;
    logic [1:0]  sz;
    logic        st;
    logic        ext;
    logic [9:0]  ra;
    logic [7:0]  rd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'hAB12, 8'h3C, 1'b0, 2'd0, 1'b0, 1'b0, 10'h012, 8'h00},
    '{1'b0, 1'b0, 16'h0012, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 10'h012, 8'h3C},
    '{1'b1, 1'b1, 16'h02F0, 8'h77, 1'b0, 2'd2, 1'b0, 1'b0, 10'h2F0, 8'h00},
    '{1'b0, 1'b1, 16'h02F0, 8'h00, 1'b0, 2'd2, 1'b0, 1'b0, 10'h2F0, 8'h77},
    '{1'b0, 1'b1, 16'h02F0, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 10'h000, 8'hAA},
    '{1'b1, 1'b1, 16'h1234, 8'h99, 1'b0, 2'd3, 1'b1, 1'b1, 10'h000, 8'h00},
    '{1'b1, 1'b0, 16'h0055, 8'hE1, 1'b1, 2'd0, 1'b0, 1'b1, 10'h000, 8'h00},
    '{1'b0, 1'b1, 16'h03FF, 8'h00, 1'b0, 2'd3, 1'b0, 1'b0, 10'h3FF, 8'h3C},
    '{1'b0, 1'b1, 16'h0400, 8'h00, 1'b0, 2'd3, 1'b0, 1'b1, 10'h000, 8'h5A},
    '{1'b0, 1'b1, 16'h00FF, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 10'h0FF, 8'h3C},
    '{1'b0, 1'b1, 16'h0100, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 10'h000, 8'h5A},
    '{1'b0, 1'b0, 16'h0055, 8'h00, 1'b1, 2'd3, 1'b1, 1'b1, 10'h000, 8'h0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic cfg_ext_only = 1'b0, cfg_stretch = 1'b0;
  logic [1:0] cfg_size = 2'd0;
  logic ram_en, ram_we;
  logic [9:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata, ad_out, ad_in, hi_addr, rdata, lat;
  logic ad_oe, hi_oe, ale, wr_n, rd_n, done, busy;
  logic [7:0] mem [1024];

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xdata_router dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_ext_only(cfg_ext_only), .cfg_size(cfg_size), .cfg_stretch(cfg_stretch),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .hi_addr(hi_addr), .hi_oe(hi_oe), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
    .rdata(rdata), .done(done), .busy(busy)
  );

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'hC3;
    ram_rdata = 8'h00;
    lat = 8'h00;
  end

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  always @(negedge clk) if (ale) lat <= ad_out;
  assign ad_in = lat ^ 8'h5A;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int n_ale = 0, n_strb = 0, lat_cyc = 0;
    logic [7:0] ale_lo = '0, ad_prev, hi_prev, got = '0;
    logic saw_ram = 1'b0, ram_w = 1'b0, pin_bad = 1'b0, hi_bad = 1'b0;
    logic wd_bad = 1'b0, seen_done = 1'b0, done_twice = 1'b0;
    logic [9:0] ram_a = '0;
    logic [7:0] ram_wd = '0;
    int n_exp = v.st ? 30 : 6;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_wide = v.wide; req_addr = v.addr;
    req_wdata = v.wd; cfg_ext_only = v.xo; cfg_size = v.sz; cfg_stretch = v.st;
    ad_prev = ad_out; hi_prev = hi_addr;
    for (int c = 1; c <= 80; c++) begin
      @(negedge clk);
      if (c == 1) req_valid = 1'b0;
      if (seen_done) begin
        done_twice = done;
        break;
      end
      if (ram_en) begin saw_ram = 1'b1; ram_a = ram_addr; ram_w = ram_we; ram_wd = ram_wdata; end
      if (!v.ext && (ale || !wr_n || !rd_n || ad_oe || hi_oe ||
                     ad_out != ad_prev || hi_addr != hi_prev)) pin_bad = 1'b1;
      if (ale) begin
        n_ale++; ale_lo = ad_out;
        if (!ad_oe) pin_bad = 1'b1;
      end
      if (!wr_n || !rd_n) begin
        n_strb++;
        if (v.wr && (wr_n || !ad_oe || ad_out != v.wd)) wd_bad = 1'b1;
        if (!v.wr && (rd_n || ad_oe)) wd_bad = 1'b1;
      end
      if (ale || !wr_n || !rd_n) begin
        if (v.wide && (!hi_oe || hi_addr != v.addr[15:8])) hi_bad = 1'b1;
        if (!v.wide && (hi_oe || hi_addr != hi_prev)) hi_bad = 1'b1;
      end
      if (done) begin seen_done = 1'b1; lat_cyc = c; got = rdata; end
    end
    if (v.ext) begin
      chk(!saw_ram && n_ale == 1, v.xo ? "R6 external route" : "R5 external route", n_ale, 1);
      chk(ale_lo == v.addr[7:0], "R7 low address on ALE", ale_lo, v.addr[7:0]);
      chk(!hi_bad, v.wide ? "R7 high address port" : "R8 high port idle", hi_bad, 0);
      chk(n_strb == n_exp, "R9 strobe length", n_strb, n_exp);
      chk(!wd_bad, "R10 strobe data phase", wd_bad, 0);
      if (!v.wr) chk(got == v.rd, "R10 external read data", got, v.rd);
      chk(lat_cyc == n_exp + 2, "R11 external done latency", lat_cyc, n_exp + 2);
    end else begin
      chk(saw_ram && ram_a == v.ra, v.wide ? "R3 internal address" : "R2 internal address", ram_a, v.ra);
      chk(ram_w == v.wr && (!v.wr || ram_wd == v.wd), "R3 internal write", ram_wd, v.wd);
      chk(!pin_bad, "R4 external pins quiet", pin_bad, 0);
      if (!v.wr) chk(got == v.rd, "R2 internal read data", got, v.rd);
      chk(lat_cyc == 2, "R11 internal done latency", lat_cyc, 2);
    end
    chk(!done_twice, "R11 done single cycle", done_twice, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && wr_n && rd_n && !ad_oe && !hi_oe && !ram_en && !done && !busy,
        "R1 reset outputs", {ale, wr_n, rd_n, ad_oe, hi_oe, ram_en, done, busy}, 8'b01100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ale && wr_n && rd_n && !busy && !done, "R1 idle after reset",
        {ale, wr_n, rd_n, busy, done}, 5'b01100);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    begin
      int n_ale = 0, n_ram = 0;
      logic [7:0] ale_lo = '0;
      logic ok_done = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b1; req_addr = 16'h0400;
      cfg_ext_only = 1'b0; cfg_size = 2'd3; cfg_stretch = 1'b1;
      @(negedge clk);
      req_write = 1'b1; req_wide = 1'b0; req_addr = 16'h0022; req_wdata = 8'hEE;
      for (int c = 0; c < 60; c++) begin
        if (ale) begin n_ale++; ale_lo = ad_out; end
        if (ram_en) n_ram++;
        if (done) begin ok_done = 1'b1; req_valid = 1'b0; break; end
        @(negedge clk);
      end
      chk(ok_done && n_ale == 1 && n_ram == 0, "R12 busy request ignored", n_ram, 0);
      chk(ale_lo == 8'h00, "R12 address phase unchanged", ale_lo, 8'h00);
      repeat (2) @(negedge clk);
      chk(!busy && !ram_en, "R12 no queued access", busy, 0);
      run_vec('{1'b0, 1'b0, 16'h0022, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 10'h022, 8'hE1});
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule